// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and date in packed BCD. Each pulse of a once-per-second tick (a 32.768 kHz clock divided by 2^15) moves the seconds, and a carry runs on through minutes, hours, day of week, day of month, month and a two-digit year. The hour register holds either 24-hour or 12-hour time. A mode flag and a PM flag sit in its top two bits. February's length comes from a settable two-bit leap counter and a two-bit leap control field. The year value does not set it.

A host loads any register through a single write port, addressed by a three-bit index: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 leap. Every register is always visible on its own read port. A write always wins over a tick in the same cycle: that tick is dropped for the whole counter.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After synchronous reset the time is 00:00:00 in 24-hour form (hour 00H), day of week 00, day 01, month 01, year 00, leap control 00 and leap counter 00.
- R2: Seconds and minutes count in BCD from 00 to 59. One tick moves the seconds by one. 59 wraps to 00 and carries into the next register in the same cycle.
- R3: With hour bit 7 = 0 (24-hour form), the hour counts 00H to 23H in BCD, and a carry out of 23H gives 00H and advances the day.
- R4: With hour bit 7 = 1 (12-hour form, bit 6 = 1 meaning PM), the sequence runs 92H (midnight), 81H..91H, D2H (noon), C1H..D1H, then back to 92H. The PM flag toggles when 11 becomes 12, and the day advances only on D1H to 92H.
- R5: A hour write stores bits 7 and 5:0 as given. Bit 6 is stored as zero whenever bit 7 is zero.
- R6: Day of week counts 00 to 06, and wraps from 06 to 00 each time the day advances.
- R7: Day of month runs from 01 to the month's last day: 30 for months 04, 06, 09 and 11; 31 for the others except 02. It then returns to 01 and advances the month. Month 12 wraps to 01 and advances the year.
- R8: February ends on day 29 when leap control bit 1 is 0 and the leap counter is 00. Otherwise it ends on day 28, so day 28 is followed by 03/01.
- R9: A write to index 7 stores data bits 7:6 as the leap control. Data bits 5:4 are loaded into the leap counter only if data bit 6 of that same write is 1. Otherwise the counter keeps its value.
- R10: The year counts 00 to 99 in BCD and wraps to 00. The leap counter adds one on every year advance and wraps from 3 to 0.
- R11: In a cycle with a write, the addressed register takes the written value and the tick of that cycle has no effect on any register.
- R12: With no tick and no write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Mode flag, PM flag, BCD hour |
| dow_o | output | 8 | Day of week 0..6 |
| day_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| leap_ctl_o | output | 2 | Leap control field |
| leap_cnt_o | output | 2 | Leap counter |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the wrap of each counter at its top value, the 23H to 00H and D1H to 92H hour transitions, the short February and the one-step leap counter advance. They also cover the PM flag staying clear in 24-hour form and a write holding off the tick. Other behaviour shows only in the bench's scenarios. These are the full carry ripple from 23:59:59 on 12/31/99 and the 30- and 31-day month ends. They also include the leap-effective 29th, the counter write protection and the complete 12-hour sequence through noon and midnight.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int LEAP_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        IDX_SEC  = 3'd0,
        IDX_MIN  = 3'd1,
        IDX_HOUR = 3'd2,
        IDX_DOW  = 3'd3,
        IDX_DAY  = 3'd4,
        IDX_MON  = 3'd5,
        IDX_YEAR = 3'd6,
        IDX_LEAP = 3'd7
    } cal_idx_e;

    typedef struct packed {
        logic       mode12;
        logic       pm;
        logic [5:0] bcd;
    } hour_reg_t;

    typedef struct packed {
        hour_reg_t hour;
        logic      day_end;
    } hour_step_t;

    function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [REG_W-1:0] last_day(input logic [REG_W-1:0] mon,
                                                 input logic leap_feb);
        logic [REG_W-1:0] r;
        case (mon)
            8'h02:                      r = leap_feb ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic hour_step_t hour_step(input hour_reg_t h);
        hour_step_t       r;
        logic [REG_W-1:0] wide;
        r.hour    = h;
        r.day_end = 1'b0;
        wide      = bcd_inc({2'b00, h.bcd});
        if (!h.mode12) begin
            r.hour.pm = 1'b0;
            if (h.bcd == 6'h23) begin
                r.hour.bcd = 6'h00;
                r.day_end  = 1'b1;
            end else begin
                r.hour.bcd = wide[5:0];
            end
        end else if (h.bcd == 6'h12) begin
            r.hour.bcd = 6'h01;
        end else if (h.bcd == 6'h11) begin
            r.hour.bcd = 6'h12;
            r.hour.pm  = ~h.pm;
            r.day_end  = h.pm;
        end else begin
            r.hour.bcd = wide[5:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter
    import cal_pkg::*;
#(
    parameter logic [REG_W-1:0] MIN_VAL = 8'h00,
    parameter logic [REG_W-1:0] MAX_VAL = 8'h59
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [REG_W-1:0] ld_val,
    input  logic             inc,
    output logic [REG_W-1:0] val,
    output logic             at_max
);

    assign at_max = (val == MAX_VAL);

    always_ff @(posedge clk) begin
        if (rst)      val <= MIN_VAL;
        else if (ld)  val <= ld_val;
        else if (inc) val <= at_max ? MIN_VAL : bcd_inc(val);
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && !inc) |=> $stable(val)); // R12
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ld && inc && val == MAX_VAL) |=> (val == MIN_VAL)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> (val == $past(ld_val))); // R11

endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [REG_W-1:0] ld_val,
    input  logic             inc,
    output logic [REG_W-1:0] hour,
    output logic             day_adv
);

    hour_reg_t  cur;
    hour_step_t step;

    assign step    = hour_step(cur);
    assign day_adv = inc && step.day_end;
    assign hour    = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (ld) begin
            cur.mode12 <= ld_val[7];
            cur.pm     <= ld_val[7] & ld_val[6];
            cur.bcd    <= ld_val[5:0];
        end else if (inc) begin
            cur <= step.hour;
        end
    end

    AST_HOUR_24_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ld && inc && hour == 8'h23) |=> (hour == 8'h00)); // R3
    AST_HOUR_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
        (!ld && inc && hour == 8'hD1) |=> (hour == 8'h92)); // R4
    AST_HOUR_PM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !hour[7] |-> !hour[6]); // R5
    AST_HOUR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> (hour[5:0] == $past(ld_val[5:0]) && hour[7] == $past(ld_val[7]))); // R5

endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  dow,
    output logic [REG_W-1:0]  day,
    output logic [REG_W-1:0]  mon,
    output logic [REG_W-1:0]  year,
    output logic [LEAP_W-1:0] leap_ctl,
    output logic [LEAP_W-1:0] leap_cnt
);

    logic ld_dow, ld_day, ld_mon, ld_year, ld_leap;
    logic dow_last, year_last;
    logic leap_feb, day_end, mon_end;
    logic [REG_W-1:0] day_top;

    assign ld_dow  = wr_en && (wr_addr == IDX_DOW);
    assign ld_day  = wr_en && (wr_addr == IDX_DAY);
    assign ld_mon  = wr_en && (wr_addr == IDX_MON);
    assign ld_year = wr_en && (wr_addr == IDX_YEAR);
    assign ld_leap = wr_en && (wr_addr == IDX_LEAP);

    assign leap_feb = !leap_ctl[1] && (leap_cnt == '0);
    assign day_top  = last_day(mon, leap_feb);
    assign day_end  = inc && (day == day_top);
    assign mon_end  = day_end && (mon == 8'h12);

    cal_wrap_counter #(.MIN_VAL(8'h00), .MAX_VAL(8'h06)) u_dow (
        .clk(clk), .rst(rst), .ld(ld_dow), .ld_val(wr_data),
        .inc(inc), .val(dow), .at_max(dow_last)
    );

    cal_wrap_counter #(.MIN_VAL(8'h00), .MAX_VAL(8'h99)) u_year (
        .clk(clk), .rst(rst), .ld(ld_year), .ld_val(wr_data),
        .inc(mon_end), .val(year), .at_max(year_last)
    );

    always_ff @(posedge clk) begin
        if (rst)         day <= 8'h01;
        else if (ld_day) day <= wr_data;
        else if (inc)    day <= day_end ? 8'h01 : bcd_inc(day);
    end

    always_ff @(posedge clk) begin
        if (rst)          mon <= 8'h01;
        else if (ld_mon)  mon <= wr_data;
        else if (day_end) mon <= mon_end ? 8'h01 : bcd_inc(mon);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            leap_ctl <= '0;
            leap_cnt <= '0;
        end else if (ld_leap) begin
            leap_ctl <= wr_data[7:6];
            if (wr_data[6]) leap_cnt <= wr_data[5:4];
        end else if (mon_end) begin
            leap_cnt <= leap_cnt + 1'b1;
        end
    end

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ld_dow && inc && dow_last) |=> (dow == 8'h00)); // R6
    AST_DAY_31_END: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && inc && day == 8'h31) |=> (day == 8'h01)); // R7
    AST_FEB_SHORT: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && inc && mon == 8'h02 && day == 8'h28 && (leap_ctl[1] || leap_cnt != 2'd0))
        |=> (day == 8'h01 && mon == 8'h03)); // R8
    AST_LEAP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && mon_end) |=> (leap_cnt == $past(leap_cnt) + 2'd1)); // R10
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && mon_end && year_last) |=> (year == 8'h00)); // R10

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  sec_o,
    output logic [REG_W-1:0]  min_o,
    output logic [REG_W-1:0]  hour_o,
    output logic [REG_W-1:0]  dow_o,
    output logic [REG_W-1:0]  day_o,
    output logic [REG_W-1:0]  month_o,
    output logic [REG_W-1:0]  year_o,
    output logic [LEAP_W-1:0] leap_ctl_o,
    output logic [LEAP_W-1:0] leap_cnt_o
);

    logic step_sec, step_min, step_hour, day_adv;
    logic sec_last, min_last;

    assign step_sec  = tick_1hz && !wr_en;
    assign step_min  = step_sec && sec_last;
    assign step_hour = step_min && min_last;

    cal_wrap_counter #(.MIN_VAL(8'h00), .MAX_VAL(8'h59)) u_sec (
        .clk(clk), .rst(rst), .ld(wr_en && wr_addr == IDX_SEC), .ld_val(wr_data),
        .inc(step_sec), .val(sec_o), .at_max(sec_last)
    );

    cal_wrap_counter #(.MIN_VAL(8'h00), .MAX_VAL(8'h59)) u_min (
        .clk(clk), .rst(rst), .ld(wr_en && wr_addr == IDX_MIN), .ld_val(wr_data),
        .inc(step_min), .val(min_o), .at_max(min_last)
    );

    cal_hour_unit u_hour (
        .clk(clk), .rst(rst), .ld(wr_en && wr_addr == IDX_HOUR), .ld_val(wr_data),
        .inc(step_hour), .hour(hour_o), .day_adv(day_adv)
    );

    cal_date_unit u_date (
        .clk(clk), .rst(rst), .inc(day_adv),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dow(dow_o), .day(day_o), .mon(month_o), .year(year_o),
        .leap_ctl(leap_ctl_o), .leap_cnt(leap_cnt_o)
    );

    AST_WRITE_BLOCKS_TICK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != IDX_SEC) |=> $stable(sec_o)); // R11

endmodule

// File: tb/bcd_calendar_clock_tb_top.sv
module bcd_calendar_clock_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, day_o, month_o, year_o;
    logic [1:0] leap_ctl_o, leap_cnt_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bcd_calendar_clock dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .day_o(day_o), .month_o(month_o), .year_o(year_o),
        .leap_ctl_o(leap_ctl_o), .leap_cnt_o(leap_cnt_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_1hz = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    endtask

    task automatic t_reset();
        check("R1 sec", sec_o, 8'h00);
        check("R1 min", min_o, 8'h00);
        check("R1 hour", hour_o, 8'h00);
        check("R1 dow", dow_o, 8'h00);
        check("R1 day", day_o, 8'h01);
        check("R1 month", month_o, 8'h01);
        check("R1 year", year_o, 8'h00);
        check("R1 leap ctl", {6'd0, leap_ctl_o}, 8'h00);
        check("R1 leap cnt", {6'd0, leap_cnt_o}, 8'h00);
    endtask

    task automatic t_seconds();
        set_hms(8'h00, 8'h00, 8'h08);
        tk(); check("R2 sec 08->09", sec_o, 8'h09);
        tk(); check("R2 sec 09->10", sec_o, 8'h10);
        set_hms(8'h09, 8'h59, 8'h59);
        tk();
        check("R3 hour 09->10", hour_o, 8'h10);
        check("R2 min wrap", min_o, 8'h00);
    endtask

    task automatic t_full_ripple();
        wr(3'd7, 8'h70);
        check("R9 leap cnt load", {6'd0, leap_cnt_o}, 8'h03);
        set_hms(8'h23, 8'h59, 8'h59);
        wr(3'd3, 8'h06); wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
        tk();
        check("R2 sec wrap", sec_o, 8'h00);
        check("R2 min wrap", min_o, 8'h00);
        check("R3 hour 23->00", hour_o, 8'h00);
        check("R6 dow 06->00", dow_o, 8'h00);
        check("R7 day 31->01", day_o, 8'h01);
        check("R7 month 12->01", month_o, 8'h01);
        check("R10 year 99->00", year_o, 8'h00);
        check("R10 leap cnt 3->0", {6'd0, leap_cnt_o}, 8'h00);
    endtask

    task automatic t_month_len();
        set_hms(8'h23, 8'h59, 8'h59);
        wr(3'd4, 8'h30); wr(3'd5, 8'h04); wr(3'd3, 8'h02);
        tk();
        check("R7 Apr 30 end day", day_o, 8'h01);
        check("R7 Apr 30 end month", month_o, 8'h05);
        check("R6 dow advance", dow_o, 8'h03);
        set_hms(8'h23, 8'h59, 8'h59);
        wr(3'd4, 8'h30);
        tk();
        check("R7 May 30->31", day_o, 8'h31);
        check("R7 May stays", month_o, 8'h05);
    endtask

    task automatic t_feb();
        wr(3'd7, 8'h40);
        set_hms(8'h23, 8'h59, 8'h59);
        wr(3'd4, 8'h28); wr(3'd5, 8'h02);
        tk();
        check("R8 leap Feb 29", day_o, 8'h29);
        set_hms(8'h23, 8'h59, 8'h59);
        tk();
        check("R8 Feb 29 -> Mar day", day_o, 8'h01);
        check("R8 Feb 29 -> Mar month", month_o, 8'h03);
        wr(3'd7, 8'h50);
        set_hms(8'h23, 8'h59, 8'h59);
        wr(3'd4, 8'h28); wr(3'd5, 8'h02);
        tk();
        check("R8 cnt1 Feb 28 end", month_o, 8'h03);
        wr(3'd7, 8'h40); wr(3'd7, 8'h80);
        check("R9 ctl 10", {6'd0, leap_ctl_o}, 8'h02);
        check("R9 cnt kept", {6'd0, leap_cnt_o}, 8'h00);
        set_hms(8'h23, 8'h59, 8'h59);
        wr(3'd4, 8'h28); wr(3'd5, 8'h02);
        tk();
        check("R8 disabled Feb 28 end day", day_o, 8'h01);
        check("R8 disabled Feb 28 end month", month_o, 8'h03);
    endtask

    task automatic t_leap_protect();
        wr(3'd7, 8'h40);
        wr(3'd7, 8'h30);
        check("R9 ctl 00", {6'd0, leap_ctl_o}, 8'h00);
        check("R9 protected cnt", {6'd0, leap_cnt_o}, 8'h00);
        wr(3'd7, 8'h60);
        check("R9 ctl 01", {6'd0, leap_ctl_o}, 8'h01);
        check("R9 cnt 2", {6'd0, leap_cnt_o}, 8'h02);
    endtask

    task automatic t_twelve_hour();
        wr(3'd4, 8'h15); wr(3'd5, 8'h06);
        set_hms(8'h91, 8'h59, 8'h59); tk();
        check("R4 11AM->noon", hour_o, 8'hD2);
        check("R4 no day advance", day_o, 8'h15);
        set_hms(8'hD2, 8'h59, 8'h59); tk();
        check("R4 noon->1PM", hour_o, 8'hC1);
        set_hms(8'hD1, 8'h59, 8'h59); tk();
        check("R4 11PM->midnight", hour_o, 8'h92);
        check("R4 day at midnight", day_o, 8'h16);
        set_hms(8'h92, 8'h59, 8'h59); tk();
        check("R4 midnight->1AM", hour_o, 8'h81);
    endtask

    task automatic t_hour_write();
        wr(3'd2, 8'h52);
        check("R5 PM cleared in 24h", hour_o, 8'h12);
        wr(3'd2, 8'hD2);
        check("R5 12h write kept", hour_o, 8'hD2);
    endtask

    task automatic t_priority();
        set_hms(8'h10, 8'h20, 8'h10);
        wr_tick(3'd0, 8'h30);
        check("R11 sec write wins", sec_o, 8'h30);
        wr(3'd0, 8'h59);
        wr_tick(3'd1, 8'h45);
        check("R11 min written", min_o, 8'h45);
        check("R11 sec not ticked", sec_o, 8'h59);
    endtask

    task automatic t_hold();
        set_hms(8'h05, 8'h06, 8'h07);
        repeat (5) @(negedge clk);
        check("R12 sec hold", sec_o, 8'h07);
        check("R12 min hold", min_o, 8'h06);
        check("R12 hour hold", hour_o, 8'h05);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_full_ripple();
        t_month_len();
        t_feb();
        t_leap_protect();
        t_twelve_hour();
        t_hour_write();
        t_priority();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule